// File: doc/BRIEF.md
# Masked Slave Select Decoder with Plug-and-Play Record Window

This block decides which slave on a shared bus owns each address phase. It looks at the top twelve address bits. It compares them against a set of base/mask region entries, with up to `N_BAR` entries for each of `N_SLV` slaves. The result is the index of the slave that owns the address, or an error flag when no enabled entry covers it. When more than one slave claims the address, the lowest-numbered slave wins and an overlap flag is raised, so that misconfigured maps can be found.

The decoder also serves a read-only window of identification records. The window sits at the top 4 KB of the address space by default. Its lower 2 KB returns one 32-bit record for each master, and its upper 2 KB returns one 32-bit record for each slave. Before operation, a simple write port loads these records into a small register array. An access that lands in the window is answered inside the block and is never routed to a slave. Every result is registered: a valid address presented in one cycle produces its outputs in the next.

Top module: `bus_addr_decoder`

## Requirements
- R1: A region entry matches when it is enabled and ((addr[31:20] XOR base) AND mask) is zero; a disabled entry never matches.
- R2: Each slave owns `N_BAR` entries (entry b of slave s at flat position s*N_BAR+b). A match on any one of them, including the last, selects that slave.
- R3: When several slaves match, `sel_idx` is the lowest matching slave index and `overlap` is 1. When exactly one slave matches, `overlap` is 0.
- R4: When nothing matches outside the window, `dec_err` is 1 and `sel_valid` is 0.
- R5: The window is hit when ((addr[31:20]^IO_BASE)&IO_MASK)==0 and ((addr[19:8]^CFG_BASE)&CFG_MASK)==0, which by default is 0xFFFFF000 to 0xFFFFFFFF. A hit sets `cfg_hit` and keeps `sel_valid` at 0 even when a slave entry also matches.
- R6: A window read with addr[11]=0 returns master record addr[10:2]; with addr[11]=1 it returns slave record addr[10:2]. `dec_err` stays 0.
- R7: A window read of a record number at or above the populated count (`N_MST` masters, `N_SLV` slaves) returns zero.
- R8: A window write gives `dec_err`=1 and `cfg_rdata`=0 and leaves every record unchanged.
- R9: Outputs reflect the address sampled at the previous rising edge while `addr_valid` was 1. A cycle with `addr_valid`=0 drives `sel_valid`, `dec_err`, `cfg_hit`, `overlap`, `sel_idx` and `cfg_rdata` to 0 on the next edge.
- R10: After reset all outputs are 0 and every record reads as zero.
- R11: With `rec_we`=1, `rec_wdata` is stored to the master record (`rec_side`=0) or slave record (`rec_side`=1) numbered `rec_idx`. A number at or above the populated count is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_valid | input | 1 | Address phase present this cycle |
| addr | input | 32 | Transaction address |
| write | input | 1 | 1 for a write transfer |
| bar_base | input | N_SLV*N_BAR*12 | Base values, 12 bits per entry |
| bar_mask | input | N_SLV*N_BAR*12 | Mask values, 12 bits per entry |
| bar_en | input | N_SLV*N_BAR | Entry enables |
| rec_we | input | 1 | Record load strobe |
| rec_side | input | 1 | Record bank: 0 master, 1 slave |
| rec_idx | input | REC_IW | Record number to load |
| rec_wdata | input | 32 | Record value to load |
| sel_valid | output | 1 | A slave was selected |
| sel_idx | output | SW | Selected slave index |
| dec_err | output | 1 | Address error response |
| cfg_hit | output | 1 | Access served by the record window |
| overlap | output | 1 | More than one slave matched |
| cfg_rdata | output | 32 | Record window read data |

## Verification
The bench uses the defaults: four slaves with four entries each, four records per bank, and the window at 0xFFFFF000. This lets it reach a match on the fourth entry of a slave, and overlaps between any slave pairs. It can also read record numbers past the populated count, and place slave regions so that they cover the window and test its precedence. Entry maps are redrawn at random at intervals, and addresses are steered into chosen regions or into the window. A 3-bit record number lets the bench issue loads past the last record and check that they are dropped.

// File: rtl/bus_dec_pkg.sv
package bus_dec_pkg;
    localparam int HI_W  = 12;
    localparam int REC_W = 32;

    function automatic logic region_hit(input logic [HI_W-1:0] hi,
                                        input logic [HI_W-1:0] base,
                                        input logic [HI_W-1:0] mask);
        return ((hi ^ base) & mask) == '0;
    endfunction
endpackage

// File: rtl/bus_dec_slave_match.sv
module bus_dec_slave_match
    import bus_dec_pkg::*;
#(
    parameter int N_BAR = 4
) (
    input  logic [HI_W-1:0]       addr_hi,
    input  logic [N_BAR*HI_W-1:0] base,
    input  logic [N_BAR*HI_W-1:0] mask,
    input  logic [N_BAR-1:0]      en,
    output logic                  hit
);
    logic [N_BAR-1:0] entry_hit;

    for (genvar b = 0; b < N_BAR; b++) begin : g_entry
        assign entry_hit[b] = en[b] &&
            region_hit(addr_hi, base[b*HI_W +: HI_W], mask[b*HI_W +: HI_W]);
    end

    assign hit = |entry_hit;
endmodule

// File: rtl/bus_dec_prio.sv
module bus_dec_prio #(
    parameter int N  = 4,
    parameter int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [SW-1:0] idx,
    output logic          any,
    output logic          multi
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = SW'(i);
        end
        any   = |req;
        multi = $countones(req) > 1;
    end
endmodule

// File: rtl/bus_dec_rec_store.sv
module bus_dec_rec_store
    import bus_dec_pkg::*;
#(
    parameter int N_MST  = 4,
    parameter int N_SREC = 4,
    parameter int REC_IW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             wside,
    input  logic [REC_IW-1:0] widx,
    input  logic [REC_W-1:0] wdata,
    input  logic             rside,
    input  logic [8:0]       rword,
    output logic [REC_W-1:0] rdata
);
    logic [REC_W-1:0] mst_d [N_MST];
    logic [REC_W-1:0] mst_q [N_MST];
    logic [REC_W-1:0] slv_d [N_SREC];
    logic [REC_W-1:0] slv_q [N_SREC];

    always_comb begin
        mst_d = mst_q;
        slv_d = slv_q;
        if (we && !wside) begin
            for (int i = 0; i < N_MST; i++)
                if (widx == REC_IW'(i)) mst_d[i] = wdata;
        end
        if (we && wside) begin
            for (int i = 0; i < N_SREC; i++)
                if (widx == REC_IW'(i)) slv_d[i] = wdata;
        end
        rdata = '0;
        if (!rside) begin
            for (int i = 0; i < N_MST; i++)
                if (rword == 9'(i)) rdata = mst_q[i];
        end else begin
            for (int i = 0; i < N_SREC; i++)
                if (rword == 9'(i)) rdata = slv_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_MST; i++)  mst_q[i] <= '0;
            for (int i = 0; i < N_SREC; i++) slv_q[i] <= '0;
        end else begin
            mst_q <= mst_d;
            slv_q <= slv_d;
        end
    end
endmodule

// File: rtl/bus_addr_decoder.sv
module bus_addr_decoder
    import bus_dec_pkg::*;
#(
    parameter int          N_SLV    = 4,
    parameter int          N_BAR    = 4,
    parameter int          N_MST    = 4,
    parameter logic [11:0] IO_BASE  = 12'hFFF,
    parameter logic [11:0] IO_MASK  = 12'hFFF,
    parameter logic [11:0] CFG_BASE = 12'hFF0,
    parameter logic [11:0] CFG_MASK = 12'hFF0,
    localparam int SW     = (N_SLV > 1) ? $clog2(N_SLV) : 1,
    localparam int MAXR   = (N_MST > N_SLV) ? N_MST : N_SLV,
    localparam int REC_IW = $clog2(MAXR) + 1,
    localparam int NE     = N_SLV * N_BAR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_valid,
    input  logic [31:0]       addr,
    input  logic              write,
    input  logic [NE*12-1:0]  bar_base,
    input  logic [NE*12-1:0]  bar_mask,
    input  logic [NE-1:0]     bar_en,
    input  logic              rec_we,
    input  logic              rec_side,
    input  logic [REC_IW-1:0] rec_idx,
    input  logic [31:0]       rec_wdata,
    output logic              sel_valid,
    output logic [SW-1:0]     sel_idx,
    output logic              dec_err,
    output logic              cfg_hit,
    output logic              overlap,
    output logic [31:0]       cfg_rdata
);
    typedef struct packed {
        logic             sel;
        logic [SW-1:0]    idx;
        logic             err;
        logic             cfg;
        logic             ovl;
        logic [REC_W-1:0] rdata;
    } res_t;

    res_t res_d, res_q;

    logic [N_SLV-1:0] slv_hit;
    logic [SW-1:0]    win_idx;
    logic             any_hit, multi_hit, in_window;
    logic [REC_W-1:0] rec_rdata;

    for (genvar s = 0; s < N_SLV; s++) begin : g_slave
        bus_dec_slave_match #(.N_BAR(N_BAR)) u_match (
            .addr_hi (addr[31:20]),
            .base    (bar_base[s*N_BAR*HI_W +: N_BAR*HI_W]),
            .mask    (bar_mask[s*N_BAR*HI_W +: N_BAR*HI_W]),
            .en      (bar_en[s*N_BAR +: N_BAR]),
            .hit     (slv_hit[s])
        );
    end

    bus_dec_prio #(.N(N_SLV), .SW(SW)) u_prio (
        .req   (slv_hit),
        .idx   (win_idx),
        .any   (any_hit),
        .multi (multi_hit)
    );

    bus_dec_rec_store #(.N_MST(N_MST), .N_SREC(N_SLV), .REC_IW(REC_IW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rec_we),
        .wside (rec_side),
        .widx  (rec_idx),
        .wdata (rec_wdata),
        .rside (addr[11]),
        .rword (addr[10:2]),
        .rdata (rec_rdata)
    );

    assign in_window = region_hit(addr[31:20], IO_BASE, IO_MASK) &&
                       region_hit(addr[19:8], CFG_BASE, CFG_MASK);

    always_comb begin
        res_d = '0;
        if (addr_valid) begin
            if (in_window) begin
                res_d.cfg   = 1'b1;
                res_d.err   = write;
                res_d.rdata = write ? '0 : rec_rdata;
            end else if (any_hit) begin
                res_d.sel = 1'b1;
                res_d.idx = win_idx;
                res_d.ovl = multi_hit;
            end else begin
                res_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign sel_valid = res_q.sel;
    assign sel_idx   = res_q.idx;
    assign dec_err   = res_q.err;
    assign cfg_hit   = res_q.cfg;
    assign overlap   = res_q.ovl;
    assign cfg_rdata = res_q.rdata;

    // R9
    idle_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |=> (!sel_valid && !dec_err && !cfg_hit && !overlap));
    // R4
    err_sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_err && sel_valid));
    // R5
    window_no_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hit |-> !sel_valid);
    // R3
    overlap_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overlap |-> sel_valid);
    // R8
    window_write_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hit && dec_err) |-> (cfg_rdata == '0));
    // R6
    window_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && in_window) |=> (cfg_hit && (dec_err == $past(write))));
endmodule

// File: tb/bus_addr_decoder_test.sv
module bus_addr_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4, NB = 4, NM = 4, NE = NS * NB;

    logic clk = 0, rst_n = 0;
    logic addr_valid = 0, write = 0;
    logic [31:0] addr = 0;
    logic [NE*12-1:0] bar_base, bar_mask;
    logic [NE-1:0] bar_en;
    logic rec_we = 0, rec_side = 0;
    logic [2:0] rec_idx = 0;
    logic [31:0] rec_wdata = 0;
    logic sel_valid, dec_err, cfg_hit, overlap;
    logic [1:0] sel_idx;
    logic [31:0] cfg_rdata;

    logic [11:0] tb_base [NE];
    logic [11:0] tb_mask [NE];
    logic        tb_en   [NE];
    logic [31:0] mrec [NM];
    logic [31:0] srec [NS];

    int checks = 0, failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int e = 0; e < NE; e++) begin
            bar_base[e*12 +: 12] = tb_base[e];
            bar_mask[e*12 +: 12] = tb_mask[e];
            bar_en[e]            = tb_en[e];
        end
    end

    bus_addr_decoder uut (
        .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr(addr),
        .write(write), .bar_base(bar_base), .bar_mask(bar_mask), .bar_en(bar_en),
        .rec_we(rec_we), .rec_side(rec_side), .rec_idx(rec_idx),
        .rec_wdata(rec_wdata), .sel_valid(sel_valid), .sel_idx(sel_idx),
        .dec_err(dec_err), .cfg_hit(cfg_hit), .overlap(overlap),
        .cfg_rdata(cfg_rdata)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model(input logic [31:0] a, input logic w,
                         output logic sv, output logic [1:0] ix, output logic er,
                         output logic cf, output logic ov, output logic [31:0] rd);
        int cnt;
        logic [8:0] wd;
        sv = 0; ix = 0; er = 0; cf = 0; ov = 0; rd = 0; cnt = 0;
        if (a[31:12] == 20'hFFFFF) begin
            cf = 1;
            er = w;
            wd = a[10:2];
            if (!w && !a[11] && wd < NM) rd = mrec[wd[1:0]];
            if (!w &&  a[11] && wd < NS) rd = srec[wd[1:0]];
        end else begin
            for (int s = NS - 1; s >= 0; s--) begin
                logic h;
                h = 0;
                for (int b = 0; b < NB; b++)
                    if (tb_en[s*NB+b] && (((a[31:20] ^ tb_base[s*NB+b]) & tb_mask[s*NB+b]) == 0))
                        h = 1;
                if (h) begin cnt++; ix = 2'(s); end
            end
            sv = (cnt > 0);
            ov = (cnt > 1);
            er = (cnt == 0);
        end
    endtask

    task automatic step(input logic [31:0] a, input logic w, input string tag);
        logic sv, er, cf, ov;
        logic [1:0] ix;
        logic [31:0] rd;
        @(negedge clk);
        addr_valid = 1; addr = a; write = w;
        model(a, w, sv, ix, er, cf, ov, rd);
        @(negedge clk);
        addr_valid = 0;
        chk(tag, "sel_valid", 32'(sel_valid), 32'(sv));
        chk(tag, "dec_err",   32'(dec_err),   32'(er));
        chk(tag, "cfg_hit",   32'(cfg_hit),   32'(cf));
        chk(tag, "overlap",   32'(overlap),   32'(ov));
        chk(tag, "cfg_rdata", cfg_rdata,      rd);
        if (sv) chk(tag, "sel_idx", 32'(sel_idx), 32'(ix));
    endtask

    task automatic load_rec(input logic side, input logic [2:0] idx, input logic [31:0] v);
        @(negedge clk);
        rec_we = 1; rec_side = side; rec_idx = idx; rec_wdata = v;
        @(negedge clk);
        rec_we = 0;
        if (!side && idx < NM) mrec[idx[1:0]] = v;
        if ( side && idx < NS) srec[idx[1:0]] = v;
    endtask

    task automatic clear_bars();
        for (int e = 0; e < NE; e++) begin
            tb_base[e] = 0; tb_mask[e] = 0; tb_en[e] = 0;
        end
    endtask

    task automatic random_bars();
        for (int e = 0; e < NE; e++) begin
            tb_base[e] = 12'($urandom);
            tb_mask[e] = 12'($urandom) | 12'hF00;
            tb_en[e]   = ($urandom % 4) != 0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_bars();
        for (int i = 0; i < NM; i++) mrec[i] = 0;
        for (int i = 0; i < NS; i++) srec[i] = 0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", "sel_valid", 32'(sel_valid), 0);
        chk("R10", "dec_err",   32'(dec_err),   0);
        chk("R10", "cfg_hit",   32'(cfg_hit),   0);
        chk("R10", "cfg_rdata", cfg_rdata,      0);
        rst_n = 1;
        step(32'hFFFFF000, 0, "R10");

        // R11 record loads, including an out-of-range number
        for (int i = 0; i < NM; i++) load_rec(0, 3'(i), 32'hA000_0000 + 32'(i));
        for (int i = 0; i < NS; i++) load_rec(1, 3'(i), 32'hB000_0000 + 32'(i));
        load_rec(0, 3'd4, 32'hDEAD_BEEF);
        step(32'hFFFFF000 + 32'(4*4), 0, "R11");
        step(32'hFFFFF800 + 32'(4*3), 0, "R11");

        // R6 both halves
        for (int i = 0; i < NM; i++) step(32'hFFFFF000 + 32'(4*i), 0, "R6");
        for (int i = 0; i < NS; i++) step(32'hFFFFF800 + 32'(4*i), 0, "R6");
        // R7 unpopulated slots
        step(32'hFFFFF7FC, 0, "R7");
        step(32'hFFFFF820, 0, "R7");
        // R8 write into the window, then read back unchanged
        step(32'hFFFFF004, 1, "R8");
        step(32'hFFFFF004, 0, "R8");

        // R4 nothing enabled
        step(32'h1234_5678, 0, "R4");
        // R2 last entry of slave 2 only
        tb_base[2*NB+3] = 12'h400; tb_mask[2*NB+3] = 12'hFF0; tb_en[2*NB+3] = 1;
        step(32'h4051_0000, 0, "R2");
        // R1 disabled entry ignored
        tb_en[2*NB+3] = 0;
        step(32'h4051_0000, 0, "R1");
        // R3 overlap: slaves 1 and 3
        tb_base[1*NB+0] = 12'h800; tb_mask[1*NB+0] = 12'hF00; tb_en[1*NB+0] = 1;
        tb_base[3*NB+2] = 12'h880; tb_mask[3*NB+2] = 12'hFF0; tb_en[3*NB+2] = 1;
        step(32'h8800_0000, 1, "R3");
        step(32'h8100_0000, 0, "R3");
        // R5 window wins over a slave covering it
        tb_base[0] = 12'hFFF; tb_mask[0] = 12'hFFF; tb_en[0] = 1;
        step(32'hFFFFF808, 0, "R5");
        step(32'hFFF0_0000, 0, "R5");
        // R9 idle cycle clears
        step(32'h8800_0000, 0, "R9");
        @(negedge clk);
        chk("R9", "sel_valid idle", 32'(sel_valid), 0);
        chk("R9", "dec_err idle",   32'(dec_err),   0);

        // R1 random sweeps
        for (int r = 0; r < 400; r++) begin
            logic [31:0] a;
            int sel;
            if (r % 50 == 0) random_bars();
            sel = $urandom % 4;
            a = $urandom;
            if (sel == 0) a[31:12] = 20'hFFFFF;
            else if (sel == 1) begin
                int e;
                e = $urandom % NE;
                a[31:20] = (tb_base[e] & tb_mask[e]) | (12'($urandom) & ~tb_mask[e]);
            end
            step(a, 1'($urandom), "R1");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule